// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port shared memory and watches what each port presents every clock: its chip enable (active low), its 14-bit address and its write strobe (active low). When both ports are enabled on the same address, one port is granted and the other is flagged with an active-low busy indication. The flagged port's write enable towards the memory is suppressed, so a losing write never reaches the array. The memory array itself, the bus drivers and the analog timing are outside this block.

The grant goes to the port whose request was standing first. A request is "fresh" in the cycle its chip enable becomes active or its address changes. If one side is fresh and the other has been standing since an earlier cycle, the standing side wins. If both are fresh, or both were standing and their addresses only now coincide without either changing, the left port wins by fixed rule. Whether an access is a read or a write plays no part in the decision. The grant is kept for as long as the collision lasts.

A strap input selects the mode. In master mode the arbiter drives both busy outputs itself. In slave mode it makes no decision. Both busy outputs rest high, and each port's write is gated only by an external busy input for that port. This lets several arbiters share one decision in a wider memory.

The ownership state machine has three states:
- `ST_FREE`: no collision is recorded.
- `ST_LEFT_OWNS`: the left port won, and the right port is busy.
- `ST_RIGHT_OWNS`: the right port won, and the left port is busy.

Its transitions are:
- From `ST_FREE` to `ST_RIGHT_OWNS` on a collision where only the left request is fresh.
- From `ST_FREE` to `ST_LEFT_OWNS` on any other collision.
- From either owning state back to `ST_FREE` when the collision ends.
- From any state to `ST_FREE` when slave mode is selected.

Top module: `dpcoll_arbiter`

## Requirements
- R1: When either chip enable is inactive, or the two addresses differ, no collision exists. In the cycle after any such cycle, both busy outputs are high.
- R2: On a collision where one port's request was already standing in the previous cycle with the same address and the other port's request is fresh, the fresh port loses. Its busy output goes low in the next cycle.
- R3: The two busy outputs are never low in the same cycle.
- R4: When both requests become fresh in the same cycle on a matching address, the left port wins and the right busy goes low in the next cycle. The same rule applies when a collision arises with neither request fresh.
- R5: The write strobes have no influence on which port wins or on the busy outputs.
- R6: In master mode, a port's write enable output is low in any cycle in which that port is the loser of the collision in that cycle. The loser is the fresh side, or the non-owner when a collision is already recorded. Otherwise the write enable output equals (chip enable active AND write strobe active).
- R7: With the strap low (slave mode), each port's write enable output is (chip enable active AND write strobe active AND its busy input high), and both busy outputs are high from the next cycle on.
- R8: A busy indication is held while the collision persists. It returns high in the cycle after either chip enable goes inactive or the addresses part.
- R9: After reset, both busy outputs are high and no winner is recorded.
- R10: All 14 address bits take part in the match; addresses that differ only in bit 13 do not collide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel | input | 1 | 1 = master (arbiter drives busy), 0 = slave (busy taken from inputs) |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_addr | input | 14 | Left address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_addr | input | 14 | Right address |
| l_busy_in_n | input | 1 | External busy for left port in slave mode, active low |
| r_busy_in_n | input | 1 | External busy for right port in slave mode, active low |
| l_busy_n | output | 1 | Left busy indication, active low |
| r_busy_n | output | 1 | Right busy indication, active low |
| l_wr_go | output | 1 | Gated left write enable to the memory, active high |
| r_wr_go | output | 1 | Gated right write enable to the memory, active high |

## Verification
A wrong ownership state shows at the busy outputs one clock after the collision cycle. It also shows in the same cycle as a write that passes, or is blocked, on the wrong side. The arrival trackers can hold a wrong previous address or enable. That flips the winner on the first collision cycle, which is visible at once on the write enables and one cycle later on busy. The reference model follows ownership cycle by cycle, and every output is compared on every cycle. So a divergence is reported within one clock of the cycle that caused it.

// File: rtl/dpc_arb_pkg.sv
package dpc_arb_pkg;

    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_LEFT_OWNS  = 2'd1,
        ST_RIGHT_OWNS = 2'd2
    } own_state_e;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_L    = 0;
    localparam int SIDE_R    = 1;

endpackage

// File: rtl/dpc_arrival_detect.sv
// Per-port request tracker: flags a request as fresh in the cycle it appears
// or moves to a new address.
module dpc_arrival_detect #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              active,
    output logic              fresh
);
    logic              prev_act_q;
    logic [ADDR_W-1:0] prev_addr_q;

    assign active = ~ce_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_act_q  <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_act_q  <= active;
            prev_addr_q <= addr;
        end
    end

    always_comb begin
        fresh = active && (!prev_act_q || (prev_addr_q != addr));
    end
endmodule

// File: rtl/dpc_addr_match.sv
// Full-width address comparator qualified by both enables and the mode strap.
module dpc_addr_match #(
    parameter int ADDR_W = 14
) (
    input  logic              master_sel,
    input  logic              a_active,
    input  logic              b_active,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              contend
);
    logic [ADDR_W-1:0] bit_eq;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_eq[i] = ~(a_addr[i] ^ b_addr[i]);
    end

    always_comb begin
        contend = master_sel && a_active && b_active && (&bit_eq);
    end
endmodule

// File: rtl/dpc_owner_fsm.sv
// Ownership state machine: records the winner of a collision and drives busy.
module dpc_owner_fsm
    import dpc_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_sel,
    input  logic contend,
    input  logic left_fresh,
    input  logic right_fresh,
    output logic left_loses,
    output logic right_loses,
    output logic l_busy_n,
    output logic r_busy_n
);
    own_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and same-cycle loser decision
    always_comb begin
        state_d     = state_q;
        left_loses  = 1'b0;
        right_loses = 1'b0;
        if (!master_sel) begin
            state_d = ST_FREE;
        end else begin
            unique case (state_q)
                ST_FREE: begin
                    if (contend) begin
                        if (left_fresh && !right_fresh) begin
                            state_d    = ST_RIGHT_OWNS;
                            left_loses = 1'b1;
                        end else begin
                            state_d     = ST_LEFT_OWNS;
                            right_loses = 1'b1;
                        end
                    end
                end
                ST_LEFT_OWNS: begin
                    if (contend) right_loses = 1'b1;
                    else         state_d     = ST_FREE;
                end
                ST_RIGHT_OWNS: begin
                    if (contend) left_loses = 1'b1;
                    else         state_d    = ST_FREE;
                end
                default: state_d = ST_FREE;
            endcase
        end
    end

    // outputs from the state register
    always_comb begin
        l_busy_n = 1'b1;
        r_busy_n = 1'b1;
        unique case (state_q)
            ST_LEFT_OWNS:  r_busy_n = 1'b0;
            ST_RIGHT_OWNS: l_busy_n = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/dpc_write_gate.sv
// Write qualifier for one port: internal loss in master mode, external busy in slave mode.
module dpc_write_gate (
    input  logic master_sel,
    input  logic active,
    input  logic we_n,
    input  logic loses_now,
    input  logic busy_in_n,
    output logic wr_go
);
    logic wr_req;

    always_comb begin
        wr_req = active && !we_n;
        if (master_sel) wr_go = wr_req && !loses_now;
        else            wr_go = wr_req && busy_in_n;
    end
endmodule

// File: rtl/dpcoll_arbiter.sv
module dpcoll_arbiter
    import dpc_arb_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_go,
    output logic              r_wr_go
);
    logic [NUM_SIDES-1:0]             ce_n_v, we_n_v, busy_in_v;
    logic [NUM_SIDES-1:0]             act_v, fresh_v, lose_v, go_v;
    logic [NUM_SIDES-1:0][ADDR_W-1:0] addr_v;
    logic                             contend;

    assign ce_n_v[SIDE_L]    = l_ce_n;
    assign ce_n_v[SIDE_R]    = r_ce_n;
    assign we_n_v[SIDE_L]    = l_we_n;
    assign we_n_v[SIDE_R]    = r_we_n;
    assign addr_v[SIDE_L]    = l_addr;
    assign addr_v[SIDE_R]    = r_addr;
    assign busy_in_v[SIDE_L] = l_busy_in_n;
    assign busy_in_v[SIDE_R] = r_busy_in_n;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dpc_arrival_detect #(.ADDR_W(ADDR_W)) u_arrive (
            .clk    (clk),
            .rst_n  (rst_n),
            .ce_n   (ce_n_v[s]),
            .addr   (addr_v[s]),
            .active (act_v[s]),
            .fresh  (fresh_v[s])
        );

        dpc_write_gate u_gate (
            .master_sel (master_sel),
            .active     (act_v[s]),
            .we_n       (we_n_v[s]),
            .loses_now  (lose_v[s]),
            .busy_in_n  (busy_in_v[s]),
            .wr_go      (go_v[s])
        );
    end

    dpc_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .master_sel (master_sel),
        .a_active   (act_v[SIDE_L]),
        .b_active   (act_v[SIDE_R]),
        .a_addr     (addr_v[SIDE_L]),
        .b_addr     (addr_v[SIDE_R]),
        .contend    (contend)
    );

    dpc_owner_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_sel  (master_sel),
        .contend     (contend),
        .left_fresh  (fresh_v[SIDE_L]),
        .right_fresh (fresh_v[SIDE_R]),
        .left_loses  (lose_v[SIDE_L]),
        .right_loses (lose_v[SIDE_R]),
        .l_busy_n    (l_busy_n),
        .r_busy_n    (r_busy_n)
    );

    assign l_wr_go = go_v[SIDE_L];
    assign r_wr_go = go_v[SIDE_R];
endmodule

// File: rtl/dpc_arb_checker.sv
module dpc_arb_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_sel,
    input logic              l_ce_n,
    input logic              l_we_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_ce_n,
    input logic              r_we_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_go,
    input logic              r_wr_go
);
    logic coll;
    assign coll = master_sel && !l_ce_n && !r_ce_n && (l_addr == r_addr);

    AST_BUSY_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n)); // R3

    AST_QUIET_WITHOUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !coll |=> (l_busy_n && r_busy_n)); // R1

    AST_AT_MOST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        coll |-> !(l_wr_go && r_wr_go)); // R6

    AST_BUSY_HELD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !r_busy_n) |=> !r_busy_n); // R8

    AST_BUSY_HELD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !l_busy_n) |=> !l_busy_n); // R8

    AST_SLAVE_INHIBIT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !l_busy_in_n) |-> !l_wr_go); // R7

    AST_SLAVE_INHIBIT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !r_busy_in_n) |-> !r_wr_go); // R7

    AST_SLAVE_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |=> (l_busy_n && r_busy_n)); // R7

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (l_busy_n && r_busy_n)); // R9
endmodule

bind dpcoll_arbiter dpc_arb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_sel  (master_sel),
    .l_ce_n      (l_ce_n),
    .l_we_n      (l_we_n),
    .l_addr      (l_addr),
    .r_ce_n      (r_ce_n),
    .r_we_n      (r_we_n),
    .r_addr      (r_addr),
    .l_busy_in_n (l_busy_in_n),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr_go     (l_wr_go),
    .r_wr_go     (r_wr_go)
);

// File: tb/dpcoll_arbiter_tb.sv
`timescale 1ns/1ps
module dpcoll_arbiter_tb;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_sel = 1'b1;
    logic          l_ce_n = 1'b1, l_we_n = 1'b1, r_ce_n = 1'b1, r_we_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic          l_busy_n, r_busy_n, l_wr_go, r_wr_go;

    int errors = 0;
    int checks = 0;

    // reference model state: 0 none, 1 left owns, 2 right owns
    int            m_owner = 0;
    bit            m_plact = 1'b0, m_pract = 1'b0;
    logic [AW-1:0] m_pla = '0, m_pra = '0;

    always #4 clk = ~clk; // 125 MHz

    dpcoll_arbiter #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare just after, advance model at posedge.
    task automatic step(input bit m, input bit lce, input bit lwe, input logic [AW-1:0] la,
                        input bit rce, input bit rwe, input logic [AW-1:0] ra,
                        input bit lbi, input bit rbi, input string tag);
        bit lact, ract, cont, lfr, rfr, lose_l, lose_r;
        int nxt;
        @(negedge clk);
        master_sel = m; l_ce_n = ~lce; l_we_n = ~lwe; l_addr = la;
        r_ce_n = ~rce; r_we_n = ~rwe; r_addr = ra;
        l_busy_in_n = lbi; r_busy_in_n = rbi;
        #1;
        lact = lce; ract = rce;
        cont = m && lact && ract && (la == ra);
        lfr  = lact && (!m_plact || m_pla != la);
        rfr  = ract && (!m_pract || m_pra != ra);
        lose_l = 1'b0; lose_r = 1'b0; nxt = 0;
        if (cont) begin
            if (m_owner == 1)      begin lose_r = 1'b1; nxt = 1; end
            else if (m_owner == 2) begin lose_l = 1'b1; nxt = 2; end
            else if (lfr && !rfr)  begin lose_l = 1'b1; nxt = 2; end
            else                   begin lose_r = 1'b1; nxt = 1; end
        end
        check(tag, "l_busy_n", l_busy_n, m_owner != 2);
        check(tag, "r_busy_n", r_busy_n, m_owner != 1);
        check({tag, "/R3"}, "busy pair", !(!l_busy_n && !r_busy_n), 1'b1);
        if (m) begin
            check(tag, "l_wr_go", l_wr_go, lact && lwe && !lose_l);
            check(tag, "r_wr_go", r_wr_go, ract && rwe && !lose_r);
        end else begin
            check(tag, "l_wr_go", l_wr_go, lact && lwe && lbi);
            check(tag, "r_wr_go", r_wr_go, ract && rwe && rbi);
        end
        @(posedge clk);
        m_owner = nxt;
        m_plact = lact; m_pla = la;
        m_pract = ract; m_pra = ra;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9", "l_busy_n after reset", l_busy_n, 1'b1);
        check("R9", "r_busy_n after reset", r_busy_n, 1'b1);

        // R1: different addresses, both writing
        repeat (3) step(1, 1, 1, 14'h0005, 1, 1, 14'h0006, 1, 1, "R1");
        // R1: one enable inactive on equal addresses
        repeat (2) step(1, 1, 1, 14'h0006, 0, 1, 14'h0006, 1, 1, "R1");
        // R10: differ only in the top bit
        repeat (2) step(1, 1, 1, 14'h2005, 1, 1, 14'h0005, 1, 1, "R10");
        step(1, 0, 0, 14'h0, 0, 0, 14'h0, 1, 1, "R1");

        // R2: left standing, right arrives -> right loses and is held (R8)
        repeat (2) step(1, 1, 0, 14'h0100, 0, 0, 14'h0000, 1, 1, "R2");
        step(1, 1, 1, 14'h0100, 1, 1, 14'h0100, 1, 1, "R2/R6");
        repeat (3) step(1, 1, 1, 14'h0100, 1, 1, 14'h0100, 1, 1, "R8/R6");
        step(1, 1, 1, 14'h0100, 0, 1, 14'h0100, 1, 1, "R8");
        step(1, 1, 1, 14'h0100, 0, 1, 14'h0100, 1, 1, "R8");
        step(1, 0, 0, 14'h0, 0, 0, 14'h0, 1, 1, "R1");

        // R2: right standing, left arrives -> left loses; release by address parting
        repeat (2) step(1, 0, 0, 14'h0000, 1, 0, 14'h3FFF, 1, 1, "R2");
        repeat (3) step(1, 1, 1, 14'h3FFF, 1, 1, 14'h3FFF, 1, 1, "R2/R6");
        step(1, 1, 1, 14'h3FFE, 1, 1, 14'h3FFF, 1, 1, "R8");
        step(1, 1, 1, 14'h3FFE, 1, 1, 14'h3FFF, 1, 1, "R8");
        step(1, 0, 0, 14'h0, 0, 0, 14'h0, 1, 1, "R1");

        // R4: both arrive together -> left wins
        repeat (3) step(1, 1, 1, 14'h0ABC, 1, 1, 14'h0ABC, 1, 1, "R4");
        step(1, 0, 0, 14'h0, 0, 0, 14'h0, 1, 1, "R4");

        // R5: same arrival pattern, only the right writes -> still left wins
        repeat (3) step(1, 1, 0, 14'h1234, 1, 1, 14'h1234, 1, 1, "R5");
        step(1, 0, 0, 14'h0, 0, 0, 14'h0, 1, 1, "R5");
        // R5: right standing with reads only, left arrives writing -> left loses
        step(1, 0, 0, 14'h0, 1, 0, 14'h0777, 1, 1, "R5");
        repeat (2) step(1, 1, 1, 14'h0777, 1, 0, 14'h0777, 1, 1, "R5");
        step(1, 0, 0, 14'h0, 0, 0, 14'h0, 1, 1, "R5");

        // R2: both standing, right moves onto left's address -> right loses
        step(1, 1, 1, 14'h0040, 1, 1, 14'h0041, 1, 1, "R2");
        repeat (2) step(1, 1, 1, 14'h0040, 1, 1, 14'h0040, 1, 1, "R2");
        // R2: left moves onto right's address while right stands
        step(1, 1, 1, 14'h0050, 1, 1, 14'h0051, 1, 1, "R2");
        repeat (2) step(1, 1, 1, 14'h0051, 1, 1, 14'h0051, 1, 1, "R2");
        step(1, 0, 0, 14'h0, 0, 0, 14'h0, 1, 1, "R1");

        // R7: slave mode, external busy gates writes, outputs stay high
        step(0, 1, 1, 14'h0200, 1, 1, 14'h0200, 0, 1, "R7");
        step(0, 1, 1, 14'h0200, 1, 1, 14'h0200, 1, 0, "R7");
        step(0, 1, 1, 14'h0200, 1, 1, 14'h0200, 1, 1, "R7");
        step(0, 1, 1, 14'h0201, 1, 1, 14'h0200, 0, 0, "R7");
        // R7: collision recorded in master, then strap drops
        step(1, 1, 1, 14'h0300, 1, 1, 14'h0300, 1, 1, "R7");
        step(1, 1, 1, 14'h0300, 1, 1, 14'h0300, 0, 0, "R7");
        repeat (2) step(0, 1, 1, 14'h0300, 1, 1, 14'h0300, 1, 0, "R7");
        repeat (2) step(1, 0, 0, 14'h0, 0, 0, 14'h0, 1, 1, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule